// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves relative branches for an 8-bit processor core. For each instruction presented with a valid strobe, it decodes the opcode. A flag marks whether the long-form prefix byte (10h) preceded the opcode. The block then tests the relevant condition-code flags and produces a taken decision and the next program counter. The inputs are the negative, zero, overflow and carry flags, the address of the instruction's first byte, and a signed offset. The offset is 8 bits for short forms, taken from its low byte, and 16 bits for long forms.

The short conditional forms occupy 20h..2Fh. They are arranged as eight complementary pairs: even opcodes test a condition and odd opcodes test its inverse. The same sixteen opcodes behind the prefix become long conditional branches. 16h is an unconditional long branch. The two subroutine forms, 8Dh (short) and 17h (long), are always taken. They also raise a push request carrying the return address. The push itself is done elsewhere.

All results are registered, so they appear one clock after the strobe and hold until the next strobe. Address arithmetic wraps at the top of the address space.

Top module: `branch_resolve_unit`

## Requirements
- R1: Results appear with `out_valid` high exactly one clock after `in_valid`. Without a strobe, `out_valid` is low and the other outputs keep their values. Synchronous reset clears every output to zero.
- R2: Opcode 20h is always taken and 21h is never taken, with or without the prefix.
- R3: 22h is taken when C and Z are both 0, and 23h when either is 1. 24h is taken when C=0 and 25h when C=1.
- R4: 26h/27h are taken on Z=0/Z=1, 28h/29h on V=0/V=1, and 2Ah/2Bh on N=0/N=1.
- R5: 2Ch is taken when N XOR V is 0 and 2Dh when it is 1. 2Eh is taken when Z OR (N XOR V) is 0 and 2Fh when it is 1.
- R6: The taken target of an unprefixed 2xh or 8Dh opcode is PC + 2 + sign-extended `off[7:0]`. Here `off[15:8]` has no effect.
- R7: With `prefix_long`=1 and a 2xh opcode, the taken target is PC + 4 + `off`.
- R8: Unprefixed 16h is always taken with target PC + 3 + `off`.
- R9: 8Dh and 17h (unprefixed) are always taken and set `push_ret`=1. For every other opcode `push_ret`=0.
- R10: A not-taken branch gives `next_pc` = PC + length. The length is 2 for short forms and 4 for prefixed forms. For any recognized opcode, `ret_pc` = PC + length, where 16h and 17h have length 3.
- R11: All address sums wrap modulo 2^16.
- R12: Any other opcode/prefix combination gives `recognized`=0, `taken`=0, `push_ret`=0, and `next_pc`=`ret_pc`=PC. This includes a prefix before 16h, 17h or 8Dh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: inputs hold a branch to resolve |
| prefix_long | input | 1 | Opcode was preceded by the 10h prefix byte |
| opcode | input | 8 | Branch opcode byte |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| pc | input | 16 | Address of the instruction's first byte |
| off | input | 16 | Signed offset (low byte only for short forms) |
| out_valid | output | 1 | Registered result valid |
| recognized | output | 1 | Opcode was a supported branch form |
| taken | output | 1 | Branch is taken |
| next_pc | output | 16 | Next program counter |
| push_ret | output | 1 | Subroutine form: return address must be pushed |
| ret_pc | output | 16 | Fall-through address |

## Verification
The assertions assume that `in_valid` is low while `rst` is high and that the opcode and prefix are sampled only in strobed cycles. The bench drives inputs on the falling edge and keeps the strobe low through reset, so both hold. The stimulus draws from all sixteen condition opcodes, the three unconditional forms and arbitrary bytes, with a random prefix. This deliberately exercises the prefixed unconditional forms that must be rejected. Flags, PC and offset are fully random, and directed cases push the PC to the top of the address space to exercise wrap.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int LEN_W = 3;

  localparam logic [7:0] OP_COND_HI = 8'h20; // upper nibble 2h
  localparam logic [7:0] OP_LONG_GO = 8'h16;
  localparam logic [7:0] OP_LONG_SUB = 8'h17;
  localparam logic [7:0] OP_SHORT_SUB = 8'h8D;

  localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
  localparam logic [LEN_W-1:0] LEN_LONGU = 3'd3;
  localparam logic [LEN_W-1:0] LEN_LONGC = 3'd4;

  typedef struct packed {
    logic             ok;     // supported form
    logic             cond;   // taken depends on flags
    logic             force_go; // unconditionally taken
    logic             wide;   // 16-bit displacement
    logic             sub;    // subroutine form
    logic [LEN_W-1:0] len;    // instruction bytes
  } br_class_t;
endpackage

// File: rtl/brx_decode.sv
module brx_decode
  import brx_pkg::*;
(
  input  logic       prefix_long,
  input  logic [7:0] opcode,
  output br_class_t  cls
);
  logic is_cond_row;

  always_comb begin
    is_cond_row = (opcode[7:4] == OP_COND_HI[7:4]);
    cls = '0;
    if (prefix_long) begin
      if (is_cond_row) begin
        cls.ok   = 1'b1;
        cls.cond = 1'b1;
        cls.wide = 1'b1;
        cls.len  = LEN_LONGC;
      end
    end else if (is_cond_row) begin
      cls.ok   = 1'b1;
      cls.cond = 1'b1;
      cls.len  = LEN_SHORT;
    end else if (opcode == OP_LONG_GO) begin
      cls.ok       = 1'b1;
      cls.force_go = 1'b1;
      cls.wide     = 1'b1;
      cls.len      = LEN_LONGU;
    end else if (opcode == OP_LONG_SUB) begin
      cls.ok       = 1'b1;
      cls.force_go = 1'b1;
      cls.wide     = 1'b1;
      cls.sub      = 1'b1;
      cls.len      = LEN_LONGU;
    end else if (opcode == OP_SHORT_SUB) begin
      cls.ok       = 1'b1;
      cls.force_go = 1'b1;
      cls.sub      = 1'b1;
      cls.len      = LEN_SHORT;
    end
  end
endmodule

// File: rtl/brx_cond.sv
module brx_cond (
  input  logic [3:0] sel,
  input  logic       fn,
  input  logic       fz,
  input  logic       fv,
  input  logic       fc,
  output logic       pass
);
  logic [7:0] base;
  logic       sgn_lt;

  always_comb begin
    sgn_lt  = fn ^ fv;
    base[0] = 1'b1;
    base[1] = ~(fc | fz);
    base[2] = ~fc;
    base[3] = ~fz;
    base[4] = ~fv;
    base[5] = ~fn;
    base[6] = ~sgn_lt;
    base[7] = ~(fz | sgn_lt);
    // odd selector inverts the pair's even test
    pass = base[sel[3:1]] ^ sel[0];
  end
endmodule

// File: rtl/brx_target.sv
module brx_target
  import brx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] off,
  input  logic [LEN_W-1:0]  len,
  input  logic              wide,
  output logic [ADDR_W-1:0] fall,
  output logic [ADDR_W-1:0] dest
);
  localparam int EXT_W = ADDR_W - SHORT_W;
  localparam int PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = wide ? off
                         : {{EXT_W{off[SHORT_W-1]}}, off[SHORT_W-1:0]};
    end else begin : g_noext
      assign disp = off;
    end
  endgenerate

  assign fall = pc + {{PAD_W{1'b0}}, len};
  assign dest = fall + disp;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OP_W    = 8,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              prefix_long,
  input  logic [OP_W-1:0]   opcode,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] off,
  output logic              out_valid,
  output logic              recognized,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              push_ret,
  output logic [ADDR_W-1:0] ret_pc
);
  br_class_t         cls;
  logic              pass;
  logic              take_c;
  logic [ADDR_W-1:0] fall;
  logic [ADDR_W-1:0] dest;
  logic [ADDR_W-1:0] next_c;
  logic [ADDR_W-1:0] ret_c;

  brx_decode u_dec (
    .prefix_long (prefix_long),
    .opcode      (opcode[7:0]),
    .cls         (cls)
  );

  brx_cond u_cond (
    .sel  (opcode[3:0]),
    .fn   (flag_n),
    .fz   (flag_z),
    .fv   (flag_v),
    .fc   (flag_c),
    .pass (pass)
  );

  brx_target #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_tgt (
    .pc   (pc),
    .off  (off),
    .len  (cls.len),
    .wide (cls.wide),
    .fall (fall),
    .dest (dest)
  );

  always_comb begin
    take_c = cls.ok & (cls.force_go | (cls.cond & pass));
    if (!cls.ok) begin
      next_c = pc;
      ret_c  = pc;
    end else begin
      next_c = take_c ? dest : fall;
      ret_c  = fall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      recognized <= 1'b0;
      taken      <= 1'b0;
      next_pc    <= '0;
      push_ret   <= 1'b0;
      ret_pc     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        recognized <= cls.ok;
        taken      <= take_c;
        next_pc    <= next_c;
        push_ret   <= cls.ok & cls.sub;
        ret_pc     <= ret_c;
      end
    end
  end
endmodule

// File: rtl/brx_checks.sv
module brx_checks #(
  parameter int ADDR_W = 16,
  parameter int OP_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              prefix_long,
  input logic [OP_W-1:0]   opcode,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] off,
  input logic              out_valid,
  input logic              recognized,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              push_ret,
  input logic [ADDR_W-1:0] ret_pc
);
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken)));

  p_always_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 8'h20) |=> taken);

  p_never_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 8'h21) |=> !taken);

  p_brn_fall_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !prefix_long && opcode == 8'h21)
      |=> next_pc == ADDR_W'($past(pc) + ADDR_W'(2)));

  p_long_go_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !prefix_long && opcode == 8'h16)
      |=> (taken && next_pc == ADDR_W'($past(pc) + ADDR_W'(3) + $past(off))));

  p_push_taken_r9: assert property (@(posedge clk) disable iff (rst)
    push_ret |-> (taken && recognized));

  p_unknown_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !recognized) |-> (!taken && !push_ret && next_pc == ret_pc));
endmodule

bind branch_resolve_unit brx_checks #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .prefix_long (prefix_long),
  .opcode      (opcode),
  .pc          (pc),
  .off         (off),
  .out_valid   (out_valid),
  .recognized  (recognized),
  .taken       (taken),
  .next_pc     (next_pc),
  .push_ret    (push_ret),
  .ret_pc      (ret_pc)
);

// File: tb/branch_resolve_unit_tb.sv
`timescale 1ns/1ps
module branch_resolve_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        prefix_long;
  logic [7:0]  opcode;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic [15:0] pc, off;
  logic        out_valid, recognized, taken, push_ret;
  logic [15:0] next_pc, ret_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_resolve_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .prefix_long(prefix_long),
    .opcode(opcode), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .pc(pc), .off(off), .out_valid(out_valid),
    .recognized(recognized), .taken(taken), .next_pc(next_pc),
    .push_ret(push_ret), .ret_pc(ret_pc)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input bit pf, input logic [7:0] op,
                       input bit n, input bit z, input bit v, input bit c,
                       input logic [15:0] p, input logic [15:0] o,
                       output bit ok, output bit tk, output bit sub,
                       output logic [15:0] nx, output logic [15:0] rt,
                       output string ctag, output string ttag);
    int len;
    logic [15:0] d;
    bit t;
    ok = 0; tk = 0; sub = 0; len = 0; d = 16'h0; ctag = "R12"; ttag = "R12";
    if (op[7:4] == 4'h2) begin
      ok = 1;
      case (op[3:1])
        3'd0: t = 1;
        3'd1: t = !(c || z);
        3'd2: t = !c;
        3'd3: t = !z;
        3'd4: t = !v;
        3'd5: t = !n;
        3'd6: t = !(n ^ v);
        default: t = !(z || (n ^ v));
      endcase
      tk = op[0] ? !t : t;
      if (op[3:1] == 3'd0) ctag = "R2";
      else if (op[3:1] <= 3'd2) ctag = "R3";
      else if (op[3:1] <= 3'd5) ctag = "R4";
      else ctag = "R5";
      if (pf) begin len = 4; d = o; ttag = "R7"; end
      else begin len = 2; d = {{8{o[7]}}, o[7:0]}; ttag = "R6"; end
    end else if (!pf && op == 8'h16) begin
      ok = 1; tk = 1; len = 3; d = o; ctag = "R8"; ttag = "R8";
    end else if (!pf && op == 8'h17) begin
      ok = 1; tk = 1; sub = 1; len = 3; d = o; ctag = "R9"; ttag = "R9";
    end else if (!pf && op == 8'h8D) begin
      ok = 1; tk = 1; sub = 1; len = 2; d = {{8{o[7]}}, o[7:0]};
      ctag = "R9"; ttag = "R6";
    end
    if (!ok) begin nx = p; rt = p; end
    else begin
      rt = p + 16'(len);
      nx = tk ? rt + d : rt;
      if (!tk) ttag = "R10";
    end
  endtask

  task automatic run_one(input bit pf, input logic [7:0] op,
                         input logic [3:0] fl, input logic [15:0] p,
                         input logic [15:0] o, input bit check_hold,
                         input string force_tag);
    bit ok, tk, sub;
    logic [15:0] nx, rt;
    string ctag, ttag;
    model(pf, op, fl[3], fl[2], fl[1], fl[0], p, o, ok, tk, sub, nx, rt, ctag, ttag);
    if (force_tag != "") begin ctag = force_tag; ttag = force_tag; end
    @(negedge clk);
    in_valid = 1; prefix_long = pf; opcode = op;
    {flag_n, flag_z, flag_v, flag_c} = fl; pc = p; off = o;
    @(negedge clk);
    in_valid = 0;
    chk("R1", "out_valid", 16'(out_valid), 16'd1);
    chk(ok ? "R12" : "R12", "recognized", 16'(recognized), 16'(ok));
    chk(ctag, "taken", 16'(taken), 16'(tk));
    chk(ttag, "next_pc", next_pc, nx);
    chk(sub ? "R9" : "R9", "push_ret", 16'(push_ret), 16'(sub));
    chk(ok ? "R10" : "R12", "ret_pc", ret_pc, rt);
    if (check_hold) begin
      // scramble inputs without a strobe; outputs must hold
      opcode = ~op; pc = ~p; off = ~o; {flag_n, flag_z, flag_v, flag_c} = ~fl;
      @(negedge clk);
      chk("R1", "idle out_valid", 16'(out_valid), 16'd0);
      chk("R1", "held next_pc", next_pc, nx);
      chk("R1", "held taken", 16'(taken), 16'(tk));
    end
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; in_valid = 0; prefix_long = 0; opcode = 8'h00;
    {flag_n, flag_z, flag_v, flag_c} = 4'h0; pc = 16'h0; off = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", 16'(out_valid), 16'd0);
    chk("R1", "reset next_pc", next_pc, 16'h0);
    chk("R1", "reset taken", 16'(taken), 16'd0);
    chk("R1", "reset push_ret", 16'(push_ret), 16'd0);
    rst = 0;

    // directed corners
    run_one(0, 8'h20, 4'h0, 16'h1000, 16'h00FE, 1, "R6");   // 0x1000
    run_one(0, 8'h20, 4'h0, 16'h1000, 16'hAB05, 0, "R6");   // high byte ignored
    run_one(0, 8'h21, 4'hF, 16'h1000, 16'h0010, 1, "R2");
    run_one(1, 8'h21, 4'h0, 16'h2000, 16'h0100, 0, "R2");
    run_one(1, 8'h27, 4'h4, 16'h2000, 16'hF000, 0, "R7");
    run_one(0, 8'h16, 4'h0, 16'h3000, 16'h8000, 0, "R8");
    run_one(0, 8'h17, 4'h0, 16'h4000, 16'h0020, 0, "R9");
    run_one(0, 8'h8D, 4'h0, 16'h4000, 16'h00F0, 0, "R9");
    run_one(1, 8'h16, 4'h0, 16'h5000, 16'h0020, 0, "R12");
    run_one(1, 8'h8D, 4'h0, 16'h5000, 16'h0020, 0, "R12");
    run_one(0, 8'h12, 4'h0, 16'h5000, 16'h0020, 1, "R12");
    run_one(0, 8'h20, 4'h0, 16'hFFFF, 16'h0001, 0, "R11");  // 0x0002
    run_one(1, 8'h20, 4'h0, 16'hFFFE, 16'h0000, 0, "R11");  // 0x0002
    run_one(0, 8'h16, 4'h0, 16'h0001, 16'hFFF0, 0, "R11");  // 0xFFF4
    run_one(0, 8'h2E, 4'h8, 16'h0100, 16'h0004, 0, "R5");   // N=1,V=0 -> not taken
    run_one(0, 8'h2D, 4'hA, 16'h0100, 16'h0004, 0, "R5");   // N=V -> not taken
    run_one(0, 8'h22, 4'h0, 16'h0100, 16'h0004, 0, "R3");
    run_one(0, 8'h23, 4'h4, 16'h0100, 16'h0004, 0, "R3");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [7:0] op;
      r = int'($urandom % 20);
      if (r < 16) op = 8'h20 + 8'(r);
      else if (r == 16) op = 8'h16;
      else if (r == 17) op = 8'h17;
      else if (r == 18) op = 8'h8D;
      else op = 8'($urandom);
      run_one(($urandom % 4) == 0, op, 4'($urandom), 16'($urandom),
              16'($urandom), (i % 16) == 0, "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule